// File: doc/BRIEF.md
# Frequency-Mark Label Character Serializer

This block draws small numeric labels under the frequency marks of a display that is scanned one vertical column at a time. The labels count upward in steps of two, starting at 2. A range select picks the last label: 14 for the low range, 28 for the high range. Every label takes two character cells. A one-digit value is padded with a blank cell on its right.

A frame-start pulse resets the mark-parity toggle. It also fills a nine-cell character queue with the start of the sequence for the selected range. When the queue advances, the cell at its tail is refilled from a sequence index. The block arms at every second frequency mark, and only when it is idle.

While a label is being drawn, each trace-start strobe loads one 7-bit column of the current character. A serial tick then shifts that column out, top pixel first. A character spans seven columns: five columns of glyph and two blank spacing columns. After those seven columns the queue moves on to the next cell. When the second cell of the label is finished, the block goes quiet until the next selected mark.

Top module: `fmark_label_serializer`

## Requirements
- R1: While reset is held and right after it, `pix_out` is 0 and `busy` is 0.
- R2: The cell sequence is the labels 2, 4, 6, … up to 14 (`range_hi`=0) or up to 28 (`range_hi`=1). Each label is two cells: a one-digit value is the digit and then a blank, and a two-digit value is the tens digit and then the units digit. Every cell after the last label is blank. Cell codes are 0–9 for the digits and 10 for blank.
- R3: After a frame start, the block arms on the second `fmark` pulse. After that it arms on every second pulse. Marks that arrive while a label is drawing still flip the parity but do not restart the label. `busy` rises in the cycle after the arming mark.
- R4: While the block is drawing, a `trace_strobe` loads one 7-bit column. Each `shift_en` cycle then presents one bit on `pix_out`, most significant (top pixel) first. After seven bits the output is 0.
- R5: Columns 0 to 4 of a cell carry the 5x7 glyph of its digit, with column 0 on the left. Columns 5 and 6 are all zero. After column 6 the queue advances to the next cell.
- R6: A label is exactly 14 columns, which is two cells. After the 14th column the block stops drawing, and `busy` falls once that column's bits have been shifted out.
- R7: `frame_start` has priority over every other input. It aborts a label in progress, clears the shift data and the parity, and restarts the sequence at label 2 with column 0.
- R8: `trace_strobe` and `shift_en` while the block is idle have no effect: `pix_out` stays 0 and `busy` stays 0.
- R9: When `trace_strobe` and `shift_en` fall in the same cycle, the load takes priority. The whole new column is then shifted out starting from its top bit.
- R10: The queue holds nine cells. Cells past the ninth are supplied in order as the queue advances, so all 14 high-range labels appear in sequence.
- R11: `range_hi` is sampled only at frame start. Changing it in the middle of a frame does not alter the labels of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame sync pulse |
| fmark | input | 1 | One-cycle frequency-mark pulse |
| trace_strobe | input | 1 | Start of a vertical trace; loads one column |
| shift_en | input | 1 | Serial clock enable; shifts one pixel out |
| range_hi | input | 1 | 0 selects labels up to 14, 1 selects labels up to 28 |
| pix_out | output | 1 | Serial pixel data, top pixel first |
| busy | output | 1 | Label drawing or column bits still pending |

## Verification
Two functions can land on the same clock edge: the parallel load of a new column and the serial shift of the register it replaces. The bench provokes this by raising `trace_strobe` and `shift_en` together on the first column of a label, when the register is empty. It expects a 0 for that tick and then all seven bits of the fresh column in order, so any lost top bit or skipped shift shows up as a mismatch. The bench also sends a frequency mark in the middle of a label and a frame start in the middle of a label. Both cases are judged by when `busy` rises next and by which label is drawn.

// File: rtl/fml_pkg.sv
package fml_pkg;

  localparam int CODE_W    = 4;
  localparam int ROWS      = 7;
  localparam int FONT_COLS = 5;
  localparam int CELL_COLS = 7;
  localparam int GLYPH_W   = ROWS * FONT_COLS;
  localparam int LO_LAST   = 14;
  localparam int HI_LAST   = 28;
  localparam logic [CODE_W-1:0] BLANK = CODE_W'(10);

  // One glyph row; bit FONT_COLS-1 is the leftmost pixel, row 0 the top.
  function automatic logic [FONT_COLS-1:0] font_row(input logic [CODE_W-1:0] d,
                                                    input int r);
    logic [GLYPH_W-1:0] g;
    case (d)
      4'd0: g = {5'h0E, 5'h11, 5'h13, 5'h15, 5'h19, 5'h11, 5'h0E};
      4'd1: g = {5'h04, 5'h0C, 5'h04, 5'h04, 5'h04, 5'h04, 5'h0E};
      4'd2: g = {5'h0E, 5'h11, 5'h01, 5'h02, 5'h04, 5'h08, 5'h1F};
      4'd3: g = {5'h1F, 5'h02, 5'h04, 5'h02, 5'h01, 5'h11, 5'h0E};
      4'd4: g = {5'h02, 5'h06, 5'h0A, 5'h12, 5'h1F, 5'h02, 5'h02};
      4'd5: g = {5'h1F, 5'h10, 5'h1E, 5'h01, 5'h01, 5'h11, 5'h0E};
      4'd6: g = {5'h06, 5'h08, 5'h10, 5'h1E, 5'h11, 5'h11, 5'h0E};
      4'd7: g = {5'h1F, 5'h01, 5'h02, 5'h04, 5'h08, 5'h08, 5'h08};
      4'd8: g = {5'h0E, 5'h11, 5'h11, 5'h0E, 5'h11, 5'h11, 5'h0E};
      4'd9: g = {5'h0E, 5'h11, 5'h11, 5'h0F, 5'h01, 5'h02, 5'h0C};
      default: g = '0;
    endcase
    return g[GLYPH_W-1-FONT_COLS*r -: FONT_COLS];
  endfunction

  // One glyph column; bit ROWS-1 is the top pixel.
  function automatic logic [ROWS-1:0] font_col(input logic [CODE_W-1:0] d,
                                               input int c);
    logic [ROWS-1:0]      col;
    logic [FONT_COLS-1:0] rw;
    col = '0;
    for (int r = 0; r < ROWS; r++) begin
      rw = font_row(d, r);
      col[ROWS-1-r] = rw[FONT_COLS-1-c];
    end
    return col;
  endfunction

  // Cell k of the label sequence for the given range.
  function automatic logic [CODE_W-1:0] cell_code(input logic hi, input int k);
    int nlab;
    int j;
    int v;
    nlab = (hi ? HI_LAST : LO_LAST) / 2;
    j    = k / 2;
    v    = 2 * (j + 1);
    if (j >= nlab) return BLANK;
    if (v < 10) return (k % 2 == 0) ? CODE_W'(v) : BLANK;
    return (k % 2 == 0) ? CODE_W'(v / 10) : CODE_W'(v % 10);
  endfunction

endpackage

// File: rtl/fml_mark_gate.sv
module fml_mark_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic fmark,
  input  logic label_done,
  output logic active
);

  logic tog_q, tog_d;
  logic act_q, act_d;
  logic start;

  always_comb begin
    start = ~frame_start & fmark & tog_q & ~act_q;
    tog_d = tog_q;
    act_d = act_q;
    if (frame_start) begin
      tog_d = 1'b0;
      act_d = 1'b0;
    end else begin
      if (fmark) tog_d = ~tog_q;
      if (start) act_d = 1'b1;
      else if (label_done) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;

  AST_ARM_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(fmark)); // R3

  AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!act_q && !tog_q)); // R7

endmodule

// File: rtl/fml_cell_seq.sv
module fml_cell_seq
  import fml_pkg::*;
#(
  parameter int COL_W = $clog2(CELL_COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             active,
  input  logic             trace_strobe,
  output logic             load,
  output logic [COL_W-1:0] col_idx,
  output logic             advance,
  output logic             label_done
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(CELL_COLS - 1);

  logic [COL_W-1:0] col_q, col_d;
  logic             chr_q, chr_d;
  logic             step;

  always_comb begin
    step       = trace_strobe & active & ~frame_start;
    advance    = step & (col_q == LAST_COL);
    label_done = advance & chr_q;
    col_d      = col_q;
    chr_d      = chr_q;
    if (frame_start) begin
      col_d = '0;
      chr_d = 1'b0;
    end else if (step) begin
      col_d = (col_q == LAST_COL) ? '0 : col_q + 1'b1;
      if (advance) chr_d = ~chr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      chr_q <= 1'b0;
    end else begin
      col_q <= col_d;
      chr_q <= chr_d;
    end
  end

  assign load    = step;
  assign col_idx = col_q;

  AST_COL_IN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST_COL); // R5

  AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(col_q) || col_q == '0); // R8

endmodule

// File: rtl/fml_char_queue.sv
module fml_char_queue
  import fml_pkg::*;
#(
  parameter int DEPTH = 9,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              range_hi,
  input  logic              advance,
  output logic [CODE_W-1:0] head
);

  localparam logic [IDX_W-1:0] IDX_MAX   = '1;
  localparam logic [IDX_W-1:0] IDX_START = IDX_W'(DEPTH);

  logic [CODE_W-1:0] cell_q [DEPTH];
  logic [CODE_W-1:0] cell_d [DEPTH];
  logic [IDX_W-1:0]  nxt_q, nxt_d;
  logic              hi_q, hi_d;

  always_comb begin
    hi_d  = hi_q;
    nxt_d = nxt_q;
    for (int i = 0; i < DEPTH; i++) cell_d[i] = cell_q[i];
    if (frame_start) begin
      hi_d  = range_hi;
      nxt_d = IDX_START;
      for (int i = 0; i < DEPTH; i++) cell_d[i] = cell_code(range_hi, i);
    end else if (advance) begin
      for (int i = 0; i < DEPTH - 1; i++) cell_d[i] = cell_q[i+1];
      cell_d[DEPTH-1] = cell_code(hi_q, int'(nxt_q));
      if (nxt_q != IDX_MAX) nxt_d = nxt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= BLANK;
      nxt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cell_q <= cell_d;
      nxt_q  <= nxt_d;
      hi_q   <= hi_d;
    end
  end

  assign head = cell_q[0];

  AST_REFILL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> nxt_q == IDX_START); // R10

  AST_RANGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(hi_q)); // R11

  AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !frame_start) |=> head == $past(cell_q[1])); // R10

endmodule

// File: rtl/fml_col_shift.sv
module fml_col_shift
  import fml_pkg::*;
#(
  parameter int COL_W = $clog2(CELL_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              load,
  input  logic [COL_W-1:0]  col_idx,
  input  logic [CODE_W-1:0] head,
  input  logic              shift_en,
  output logic              pix,
  output logic              pending
);

  localparam int CNT_W = $clog2(ROWS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ROWS);

  logic [ROWS-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROWS-1:0]  col_bits;

  always_comb begin
    col_bits = (int'(col_idx) < FONT_COLS) ? font_col(head, int'(col_idx)) : '0;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (frame_start) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (load) begin
      sh_d  = col_bits;
      cnt_d = FULL;
    end else if (shift_en && cnt_q != '0) begin
      sh_d  = {sh_q[ROWS-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign pix     = sh_q[ROWS-1] & (cnt_q != '0);
  assign pending = (cnt_q != '0);

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !frame_start) |=> cnt_q == FULL); // R9

  AST_ONE_BIT_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load && !frame_start && cnt_q != '0)
      |=> cnt_q == $past(cnt_q) - 1'b1); // R4

  AST_SPACER_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !frame_start && int'(col_idx) >= FONT_COLS) |=> sh_q == '0); // R5

endmodule

// File: rtl/fmark_label_serializer.sv
module fmark_label_serializer
  import fml_pkg::*;
#(
  parameter int QUEUE_DEPTH = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic fmark,
  input  logic trace_strobe,
  input  logic shift_en,
  input  logic range_hi,
  output logic pix_out,
  output logic busy
);

  localparam int COL_W = $clog2(CELL_COLS);
  localparam int IDX_W = $clog2(HI_LAST + QUEUE_DEPTH + 1);

  logic              active;
  logic              load;
  logic              advance;
  logic              label_done;
  logic [COL_W-1:0]  col_idx;
  logic [CODE_W-1:0] head;
  logic              pending;

  fml_mark_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .fmark       (fmark),
    .label_done  (label_done),
    .active      (active)
  );

  fml_cell_seq #(.COL_W(COL_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start  (frame_start),
    .active       (active),
    .trace_strobe (trace_strobe),
    .load         (load),
    .col_idx      (col_idx),
    .advance      (advance),
    .label_done   (label_done)
  );

  fml_char_queue #(.DEPTH(QUEUE_DEPTH), .IDX_W(IDX_W)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .range_hi    (range_hi),
    .advance     (advance),
    .head        (head)
  );

  fml_col_shift #(.COL_W(COL_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .load        (load),
    .col_idx     (col_idx),
    .head        (head),
    .shift_en    (shift_en),
    .pix         (pix_out),
    .pending     (pending)
  );

  assign busy = active | pending;

  AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pix_out); // R8

  AST_DONE_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (label_done && !frame_start) |=> !active); // R6

endmodule

// File: tb/tb_fmark_label_serializer.sv
module tb_fmark_label_serializer;

  logic clk = 1'b0;
  logic rst_n, frame_start, fmark, trace_strobe, shift_en, range_hi;
  logic pix_out, busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  fmark_label_serializer dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fmark(fmark),
    .trace_strobe(trace_strobe), .shift_en(shift_en), .range_hi(range_hi),
    .pix_out(pix_out), .busy(busy)
  );

  // Glyph rows, top first, bit 4 = left pixel.
  function automatic logic [4:0] g_row(input int d, input int r);
    logic [4:0] t [7];
    case (d)
      0: t = '{5'h0E, 5'h11, 5'h13, 5'h15, 5'h19, 5'h11, 5'h0E};
      1: t = '{5'h04, 5'h0C, 5'h04, 5'h04, 5'h04, 5'h04, 5'h0E};
      2: t = '{5'h0E, 5'h11, 5'h01, 5'h02, 5'h04, 5'h08, 5'h1F};
      3: t = '{5'h1F, 5'h02, 5'h04, 5'h02, 5'h01, 5'h11, 5'h0E};
      4: t = '{5'h02, 5'h06, 5'h0A, 5'h12, 5'h1F, 5'h02, 5'h02};
      5: t = '{5'h1F, 5'h10, 5'h1E, 5'h01, 5'h01, 5'h11, 5'h0E};
      6: t = '{5'h06, 5'h08, 5'h10, 5'h1E, 5'h11, 5'h11, 5'h0E};
      7: t = '{5'h1F, 5'h01, 5'h02, 5'h04, 5'h08, 5'h08, 5'h08};
      8: t = '{5'h0E, 5'h11, 5'h11, 5'h0E, 5'h11, 5'h11, 5'h0E};
      9: t = '{5'h0E, 5'h11, 5'h11, 5'h0F, 5'h01, 5'h02, 5'h0C};
      default: t = '{5'h0, 5'h0, 5'h0, 5'h0, 5'h0, 5'h0, 5'h0};
    endcase
    return t[r];
  endfunction

  // Expected cell code (10 = blank) from the label text.
  function automatic int exp_cell(input bit hi, input int k);
    int    lab;
    int    last;
    string s;
    lab  = k / 2;
    last = hi ? 28 : 14;
    if (2 * (lab + 1) > last) return 10;
    s = $sformatf("%0d", 2 * (lab + 1));
    if (k % 2 >= s.len()) return 10;
    return int'(s[k % 2]) - 48;
  endfunction

  function automatic logic [6:0] exp_col(input int code, input int c);
    logic [6:0] v;
    logic [4:0] rw;
    v = '0;
    if (code > 9 || c > 4) return v;
    for (int r = 0; r < 7; r++) begin
      rw = g_row(code, r);
      v[6-r] = rw[4-c];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compare every shifted pixel against the scoreboard.
  always @(negedge clk) begin
    if (!done && rst_n && shift_en) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected tick", 1, 0);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, int'(pix_out), int'(e));
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input bit b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic new_frame(input bit hi);
    range_hi    = hi;
    frame_start = 1'b1;
    step();
    frame_start = 1'b0;
  endtask

  task automatic mark(input bit exp_busy, input string tag);
    fmark = 1'b1;
    step();
    fmark = 1'b0;
    @(negedge clk);
    chk(tag, int'(busy), int'(exp_busy));
    step();
  endtask

  task automatic do_trace(input logic [6:0] bits, input bit collide, input string tag);
    trace_strobe = 1'b1;
    shift_en     = collide;
    if (collide) push(1'b0, tag);
    step();
    trace_strobe = 1'b0;
    shift_en     = 1'b1;
    for (int b = 6; b >= 0; b--) push(bits[b], tag);
    repeat (7) step();
    shift_en = 1'b0;
  endtask

  task automatic idle_trace(input string tag);
    trace_strobe = 1'b1;
    step();
    trace_strobe = 1'b0;
    shift_en     = 1'b1;
    for (int b = 0; b < 7; b++) push(1'b0, tag);
    repeat (7) step();
    shift_en = 1'b0;
    @(negedge clk);
    chk(tag, int'(busy), 0);
    step();
  endtask

  task automatic draw_label(input bit hi, input int lab, input bit collide,
                            input bit mid_mark, input string tag);
    for (int ch = 0; ch < 2; ch++) begin
      for (int c = 0; c < 7; c++) begin
        do_trace(exp_col(exp_cell(hi, 2 * lab + ch), c),
                 collide && ch == 0 && c == 0, tag);
        if (mid_mark && ch == 0 && c == 0) mark(1'b1, "R3 mark while drawing");
      end
    end
    @(negedge clk);
    chk({tag, " R6 busy after label"}, int'(busy), 0);
    chk({tag, " R6 pix after label"}, int'(pix_out), 0);
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; fmark = 1'b0;
    trace_strobe = 1'b0; shift_en = 1'b0; range_hi = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pix in reset", int'(pix_out), 0);
    chk("R1 busy in reset", int'(busy), 0);
    step();
    rst_n = 1'b1;
    step();
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    step();

    // Low range frame
    new_frame(1'b0);
    idle_trace("R8 idle strobe");
    mark(1'b0, "R3 first mark idle");
    mark(1'b1, "R3 second mark arms");
    draw_label(1'b0, 0, 1'b0, 1'b0, "R2 R4 R5 label 2");
    mark(1'b0, "R3 third mark idle");
    mark(1'b1, "R3 fourth mark arms");
    draw_label(1'b0, 1, 1'b1, 1'b0, "R9 collide label 4");
    mark(1'b0, "R3 odd mark");
    mark(1'b1, "R3 even mark");
    draw_label(1'b0, 2, 1'b0, 1'b1, "R3 label 6");
    mark(1'b1, "R3 parity kept across busy");
    draw_label(1'b0, 3, 1'b0, 1'b0, "R3 label 8");
    for (int lab = 4; lab < 8; lab++) begin
      mark(1'b0, "R3 odd mark");
      mark(1'b1, "R3 even mark");
      draw_label(1'b0, lab, 1'b0, 1'b0, "R2 R5 low range");
    end

    // High range frame; range change mid-frame must be ignored
    new_frame(1'b1);
    range_hi = 1'b0;
    for (int lab = 0; lab < 15; lab++) begin
      mark(1'b0, "R3 odd mark");
      mark(1'b1, "R3 even mark");
      draw_label(1'b1, lab, 1'b0, 1'b0, "R10 R11 high range");
    end

    // Abort in the middle of a label
    new_frame(1'b0);
    mark(1'b0, "R3 odd mark");
    mark(1'b1, "R3 even mark");
    for (int c = 0; c < 3; c++) do_trace(exp_col(2, c), 1'b0, "R7 before abort");
    frame_start = 1'b1;
    step();
    frame_start = 1'b0;
    @(negedge clk);
    chk("R7 busy after abort", int'(busy), 0);
    chk("R7 pix after abort", int'(pix_out), 0);
    step();
    idle_trace("R7 R8 idle after abort");
    mark(1'b0, "R7 parity cleared");
    mark(1'b1, "R7 rearm");
    draw_label(1'b0, 0, 1'b0, 1'b0, "R7 restart at 2");

    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule